// File: doc/BRIEF.md
# Page Write Load Controller for a Byte-Wide Nonvolatile Memory

This block sits between a host that drives byte-wide memory-style strobes and the programming logic of a nonvolatile array. All host pins are sampled on the system clock. A write happens while chip-select and write-strobe are both low with output-enable high. The block gathers the bytes of one page into a 64-byte buffer. The page is fixed by the first byte, and the low address bits choose the lane for each byte. When no new byte arrives for a programmable number of cycles, loading closes. The block then holds busy for a programmable programming time and ends it with a one-cycle commit that carries the page number, the byte-valid mask and the page data.

The controller is a three-state machine. ST_IDLE waits for the first byte. T_FIRST moves it to ST_LOAD when the first byte completes. ST_LOAD accepts further bytes and restarts the inactivity count on each one. T_EXPIRE moves it to ST_PROG when the count runs out. ST_PROG reports busy and ignores the host. T_DONE returns it to ST_IDLE with the commit pulse. T_ABORT, taken from any state while the host reset pin is low, returns it to ST_IDLE with nothing committed. The storage array that consumes the commit is outside the block.

Top module: `pgwr_ctrl`

## Requirements
- R1: A byte is taken only from a strobe during which chip-select and write-strobe are both low, output-enable is high and the host reset pin is high. A strobe that does not meet this takes no byte and starts no page.
- R2: The address is sampled in the first clock cycle in which both strobes are low, which is the fall of the later strobe. The data is sampled in the first cycle in which they are no longer both low, which is the rise of the earlier strobe.
- R3: The commit page number is address bits 14..6 of the first byte of a page. Those bits are ignored on every later byte of the same page.
- R4: Address bits 5..0 pick lane i. Lane i sets commit_mask bit i and fills commit_data bits 8i+7..8i. A second write to the same lane keeps the newer byte.
- R5: Loading ends when WIN_CYC clock edges have passed after the edge that took the last byte, with no strobe active. busy is first seen high after edge number WIN_CYC+1, counting the byte-taking edge as edge 1.
- R6: busy stays high for PROG_CYC cycles. Strobes during busy load no byte and start no page.
- R7: commit is high for exactly one cycle, and that cycle is the last busy cycle. It is first seen after edge WIN_CYC+PROG_CYC, counted as in R5. After reset, busy and commit are low.
- R8: While the host reset pin is low, busy is low from the next cycle, no commit is issued and the bytes loaded so far are discarded.
- R9: Lanes that were not written have mask bit 0, so the array keeps their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous system reset, active low |
| hst_addr | input | 15 | Host byte address |
| hst_din | input | 8 | Host write data |
| hst_cs_n | input | 1 | Chip-select, active low |
| hst_we_n | input | 1 | Write strobe, active low |
| hst_oe_n | input | 1 | Output-enable, active low |
| hst_rst_n | input | 1 | Host reset pin, active low; aborts and blocks |
| busy | output | 1 | Programming in progress |
| commit | output | 1 | One-cycle pulse at the end of programming |
| commit_page | output | 9 | Page number, valid with commit |
| commit_mask | output | 64 | Loaded-lane mask, valid with commit |
| commit_data | output | 512 | Page bytes, lane i at bits 8i+7..8i |

## Verification
A wrong state register shows up at the ports within one programming period. It appears as a busy edge that is early or late relative to the last byte, as a commit outside the last busy cycle, or as a commit that never comes. A wrong lane or page latch appears only at the commit, as a wrong mask bit, a wrong byte or a wrong page number. For that reason every sequence is carried through to its commit or, for ignored strobes, to the point where a commit would have been due.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pgwr_state_e;
endpackage

// File: rtl/pgwr_strobe.sv
// Host strobe qualifier: detects start (address sample) and end (data sample)
module pgwr_strobe #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              hrst_n,
    output logic              active,
    output logic              done,
    output logic [ADDR_W-1:0] addr_q
);
    logic both_low;
    logic act_q;

    assign both_low = !cs_n && !we_n;
    assign active   = both_low && oe_n && hrst_n;
    // data sampled when the first strobe rises after a qualified strobe
    assign done     = act_q && !both_low && oe_n && hrst_n;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            act_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            act_q <= active;
            if (active && !act_q)
                addr_q <= addr;   // fall of the later strobe
        end
    end
endmodule

// File: rtl/pgwr_count.sv
// Up counter with synchronous clear
module pgwr_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)  cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pgwr_pagebuf.sv
// Page byte lanes with per-lane valid flag
module pgwr_pagebuf #(
    parameter int OFS_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          arst_n,
    input  logic                          wr,
    input  logic [OFS_W-1:0]              ofs,
    input  logic [DATA_W-1:0]             din,
    input  logic                          clr,
    output logic [(1<<OFS_W)-1:0]         mask,
    output logic [(1<<OFS_W)*DATA_W-1:0]  data
);
    localparam int NB = 1 << OFS_W;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic              vld;
        logic [DATA_W-1:0] byt;
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                vld <= 1'b0;
                byt <= '0;
            end else if (clr) begin
                vld <= 1'b0;
            end else if (wr && ofs == OFS_W'(i)) begin
                vld <= 1'b1;
                byt <= din;
            end
        end
        assign mask[i]                   = vld;
        assign data[i*DATA_W +: DATA_W]  = byt;
    end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int OFS_W    = 6,
    parameter int WIN_CYC  = 3750,
    parameter int PROG_CYC = 1250000
) (
    input  logic                                clk,
    input  logic                                arst_n,
    input  logic [ADDR_W-1:0]                   hst_addr,
    input  logic [DATA_W-1:0]                   hst_din,
    input  logic                                hst_cs_n,
    input  logic                                hst_we_n,
    input  logic                                hst_oe_n,
    input  logic                                hst_rst_n,
    output logic                                busy,
    output logic                                commit,
    output logic [ADDR_W-OFS_W-1:0]             commit_page,
    output logic [(1<<OFS_W)-1:0]               commit_mask,
    output logic [(1<<OFS_W)*DATA_W-1:0]        commit_data
);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int WIN_W  = $clog2(WIN_CYC + 1);
    localparam int PRG_W  = $clog2(PROG_CYC + 1);

    pgwr_state_e state, state_nx;

    logic              stb_act, stb_done;
    logic [ADDR_W-1:0] stb_addr;
    logic [WIN_W-1:0]  win_cnt;
    logic [PRG_W-1:0]  prg_cnt;
    logic              win_hit, prg_hit, byte_wr, buf_clr;
    logic [PAGE_W-1:0] page_q;

    pgwr_strobe #(.ADDR_W(ADDR_W)) u_stb (
        .clk(clk), .arst_n(arst_n), .addr(hst_addr),
        .cs_n(hst_cs_n), .we_n(hst_we_n), .oe_n(hst_oe_n), .hrst_n(hst_rst_n),
        .active(stb_act), .done(stb_done), .addr_q(stb_addr)
    );

    pgwr_count #(.W(WIN_W)) u_win (
        .clk(clk), .arst_n(arst_n),
        .clr(state != ST_LOAD || stb_done || stb_act),
        .cnt(win_cnt)
    );

    pgwr_count #(.W(PRG_W)) u_prg (
        .clk(clk), .arst_n(arst_n),
        .clr(state != ST_PROG),
        .cnt(prg_cnt)
    );

    assign win_hit = (win_cnt == WIN_W'(WIN_CYC - 1)) && !stb_act;
    assign prg_hit = (prg_cnt == PRG_W'(PROG_CYC - 1));
    assign byte_wr = stb_done && (state != ST_PROG);
    assign buf_clr = commit || !hst_rst_n;

    pgwr_pagebuf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .arst_n(arst_n), .wr(byte_wr),
        .ofs(stb_addr[OFS_W-1:0]), .din(hst_din), .clr(buf_clr),
        .mask(commit_mask), .data(commit_data)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (stb_done) state_nx = ST_LOAD;   // T_FIRST
            ST_LOAD: if (win_hit)  state_nx = ST_PROG;   // T_EXPIRE
            ST_PROG: if (prg_hit)  state_nx = ST_IDLE;   // T_DONE
            default:               state_nx = ST_IDLE;
        endcase
        if (!hst_rst_n) state_nx = ST_IDLE;              // T_ABORT
    end

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= ST_IDLE;
        else         state <= state_nx;
    end

    // page number frozen by the first byte of the page
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            page_q <= '0;
        else if (state == ST_IDLE && stb_done)
            page_q <= stb_addr[ADDR_W-1:OFS_W];
    end

    // outputs
    always_comb begin
        busy        = (state == ST_PROG);
        commit      = (state == ST_PROG) && prg_hit && hst_rst_n;
        commit_page = page_q;
    end
endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
    parameter int PW = 9,
    parameter int MW = 64
) (
    input logic          clk,
    input logic          arst_n,
    input logic          hst_rst_n,
    input logic          busy,
    input logic          commit,
    input logic [PW-1:0] commit_page,
    input logic [MW-1:0] commit_mask
);
    // R8: host reset drops busy on the next cycle
    a_r8_abort_busy: assert property (@(posedge clk) disable iff (!arst_n)
        !hst_rst_n |=> !busy);
    // R8: no commit while host reset is low
    a_r8_no_commit: assert property (@(posedge clk) disable iff (!arst_n)
        !hst_rst_n |-> !commit);
    // R7: commit lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!arst_n)
        commit |=> !commit);
    // R7: commit only inside a busy period
    a_r7_commit_busy: assert property (@(posedge clk) disable iff (!arst_n)
        commit |-> busy);
    // R6: no lane changes while programming
    a_r6_mask_frozen: assert property (@(posedge clk) disable iff (!arst_n)
        (busy && $past(busy)) |-> $stable(commit_mask));
    // R3: page number holds while the page has bytes
    a_r3_page_hold: assert property (@(posedge clk) disable iff (!arst_n)
        ((|commit_mask) && $past(|commit_mask)) |-> $stable(commit_page));
    // R5: programming never starts on an empty page
    a_r5_busy_has_bytes: assert property (@(posedge clk) disable iff (!arst_n)
        busy |-> (|commit_mask));
endmodule

bind pgwr_ctrl pgwr_chk #(.PW(ADDR_W - OFS_W), .MW(1 << OFS_W)) u_chk (
    .clk(clk), .arst_n(arst_n), .hst_rst_n(hst_rst_n), .busy(busy),
    .commit(commit), .commit_page(commit_page), .commit_mask(commit_mask)
);

// File: tb/tb_pgwr_ctrl.sv
module tb_pgwr_ctrl;
    localparam int WIN  = 8;
    localparam int PRG  = 20;
    localparam int NVEC = 6;
    // {address, data}
    localparam logic [22:0] VEC [NVEC] = '{
        {9'h0AB, 6'd5,  8'h11},
        {9'h0AB, 6'd0,  8'h22},
        {9'h0AB, 6'd63, 8'h33},
        {9'h1FF, 6'd9,  8'h44},   // other page bits: ignored (R3)
        {9'h0AB, 6'd5,  8'h55},   // overwrite lane 5 (R4)
        {9'h000, 6'd32, 8'h66}
    };

    logic         clk = 1'b0;
    logic         arst_n = 1'b0;
    logic [14:0]  hst_addr = '0;
    logic [7:0]   hst_din = '0;
    logic         hst_cs_n = 1'b1, hst_we_n = 1'b1, hst_oe_n = 1'b1, hst_rst_n = 1'b1;
    logic         busy, commit;
    logic [8:0]   commit_page;
    logic [63:0]  commit_mask;
    logic [511:0] commit_data;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pgwr_ctrl #(.WIN_CYC(WIN), .PROG_CYC(PRG)) dut (
        .clk(clk), .arst_n(arst_n), .hst_addr(hst_addr), .hst_din(hst_din),
        .hst_cs_n(hst_cs_n), .hst_we_n(hst_we_n), .hst_oe_n(hst_oe_n),
        .hst_rst_n(hst_rst_n), .busy(busy), .commit(commit),
        .commit_page(commit_page), .commit_mask(commit_mask),
        .commit_data(commit_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [14:0] a, input logic [7:0] d, input logic oe);
        @(negedge clk);
        hst_addr = a; hst_din = d; hst_oe_n = oe; hst_cs_n = 1'b0; hst_we_n = 1'b0;
        @(negedge clk);
        hst_cs_n = 1'b1; hst_we_n = 1'b1;
    endtask

    // counts edges from the release edge until commit is seen
    task automatic wait_commit(output int n, output int nb);
        n = 0; nb = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (busy && nb == 0) nb = n;
            if (commit) return;
        end
        n = -1;
    endtask

    task automatic no_commit(input int cyc, input string req);
        int seen = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (commit || busy) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0]  exp_mask;
        logic [511:0] exp_data;
        int n, nb;

        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk(busy == 1'b0 && commit == 1'b0, "R7 reset state", {busy, commit}, 0);

        // table-driven page load
        exp_mask = '0; exp_data = '0;
        for (int i = 0; i < NVEC; i++) begin
            wr_byte(VEC[i][22:8], VEC[i][7:0], 1'b1);
            exp_mask[VEC[i][13:8]] = 1'b1;
            exp_data[VEC[i][13:8]*8 +: 8] = VEC[i][7:0];
            if (i < NVEC - 1) begin
                @(negedge clk); @(negedge clk);
                chk(busy == 1'b0, "R5 loading continues within window", busy, 0);
            end
        end
        wait_commit(n, nb);
        chk(nb == WIN + 1, "R5 busy start", nb, WIN + 1);
        chk(n == WIN + PRG, "R7 commit timing", n, WIN + PRG);
        chk(nb > 0 && n - nb + 1 == PRG, "R6 busy length", n - nb + 1, PRG);
        chk(commit_page == 9'h0AB, "R3 page frozen", commit_page, 9'h0AB);
        chk(commit_mask == exp_mask, "R4 R9 lane mask", commit_mask, exp_mask);
        for (int b = 0; b < 64; b++)
            if (exp_mask[b])
                chk(commit_data[b*8 +: 8] == exp_data[b*8 +: 8], "R4 lane data",
                    commit_data[b*8 +: 8], exp_data[b*8 +: 8]);
        @(negedge clk);
        chk(commit == 1'b0 && busy == 1'b0, "R7 single pulse", {busy, commit}, 0);

        // R1: output-enable low blocks the write
        wr_byte({9'h010, 6'd3}, 8'hA5, 1'b0);
        hst_oe_n = 1'b1;
        no_commit(WIN + PRG + 4, "R1 oe low ignored");
        // R1: write strobe alone does nothing
        @(negedge clk); hst_we_n = 1'b0;
        @(negedge clk); hst_we_n = 1'b1;
        no_commit(WIN + PRG + 4, "R1 single strobe ignored");

        // R6: strobes during busy are ignored
        wr_byte({9'h021, 6'd1}, 8'h77, 1'b1);
        while (!busy) @(negedge clk);
        wr_byte({9'h033, 6'd2}, 8'h88, 1'b1);
        wait_commit(n, nb);
        chk(commit_mask == 64'h2, "R6 busy strobe not loaded", commit_mask, 64'h2);
        chk(commit_page == 9'h021, "R6 busy strobe no new page", commit_page, 9'h021);
        no_commit(WIN + PRG + 4, "R6 no follow-up page");

        // R8: host reset aborts programming
        wr_byte({9'h044, 6'd7}, 8'h99, 1'b1);
        while (!busy) @(negedge clk);
        hst_rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy drops", busy, 0);
        wr_byte({9'h045, 6'd8}, 8'h9A, 1'b1);   // blocked while reset low
        @(negedge clk); hst_rst_n = 1'b1;
        no_commit(WIN + PRG + 4, "R8 aborted page not committed");

        // R8: reset during loading discards bytes
        wr_byte({9'h050, 6'd4}, 8'h5A, 1'b1);
        @(negedge clk); hst_rst_n = 1'b0;
        @(negedge clk); hst_rst_n = 1'b1;
        no_commit(WIN + PRG + 4, "R8 loaded bytes discarded");

        // R2: address at later fall, data at earlier rise
        @(negedge clk); hst_addr = {9'h066, 6'd10}; hst_din = 8'h00; hst_cs_n = 1'b0;
        @(negedge clk); hst_addr = {9'h067, 6'd12}; hst_din = 8'hC3; hst_we_n = 1'b0;
        @(negedge clk); hst_addr = {9'h068, 6'd14}; hst_we_n = 1'b1;
        @(negedge clk); hst_din = 8'h3C; hst_cs_n = 1'b1;
        wait_commit(n, nb);
        chk(commit_mask == (64'h1 << 12), "R2 address sample point", commit_mask, 64'h1 << 12);
        chk(commit_page == 9'h067, "R2 page sample point", commit_page, 9'h067);
        chk(commit_data[12*8 +: 8] == 8'hC3, "R2 data sample point", commit_data[12*8 +: 8], 8'hC3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule